// File: doc/BRIEF.md
# Four-Channel Window Comparator Interrupt

This block monitors four sampled 10-bit magnitudes. Each channel has its own upper and lower limit. When a channel presents a new sample, the block compares that sample against both limits. Any excursion sets a sticky bit in an 8-bit status byte. The interrupt request output is asserted while at least one set bit belongs to a limit that is programmed to a non-zero value.

A host reads the status byte by pulsing a read strobe. The host samples the byte in the same cycle as the strobe. The whole byte then clears on the next clock edge. The one exception is an excursion that lands in that same cycle: it stays recorded, so no event is lost.

The latest sample of any channel can be read back as two bytes. The host selects the channel with a channel-select input. Samples arrive on a per-channel valid strobe and are always accepted, so the input side never applies back-pressure. The limits are plain level inputs.

Top module: `quad_window_irq`

## Requirements
- R1: Channel k (k = 0..3) reports its high-limit flag in status bit 2k+1 and its low-limit flag in status bit 2k. The odd bits are therefore the high flags and the even bits are the low flags.
- R2: A clock edge with `sample_valid[k]` high and the channel's sample strictly greater than its upper limit sets status bit 2k+1. A sample equal to the limit does not set the bit.
- R3: A clock edge with `sample_valid[k]` high and the channel's sample strictly less than its lower limit sets status bit 2k. A sample equal to the limit does not set the bit.
- R4: Comparisons happen only on edges where the channel's valid bit is high. Changes to the sample bus without a valid bit leave the status byte unchanged.
- R5: Flags are sticky. A set bit stays set until a read strobe, even if later samples fall back inside the window.
- R6: During the cycle where `flag_rd` is high, `flags_o` still shows the pre-read value. On the following edge every bit returns to 0.
- R7: An excursion detected on the same edge as a read strobe leaves its bit set after the clear.
- R8: `irq_o` equals the OR of each set high flag whose upper limit is non-zero and each set low flag whose lower limit is non-zero. It follows the status register and limits without added delay, so it drops in the cycle after a clear.
- R9: A limit programmed to zero still lets its flag set and read back in `flags_o`. That flag never drives `irq_o`.
- R10: One cycle after a valid strobe on a channel, the readback bytes for that channel are available. The `rd_chan` input selects the channel: 0 to 3 picks channels 0 to 3. `data_lo_o` carries sample bits 7:0. `data_hi_o` carries sample bits 9:8 in its bits 1:0, with bits 7:2 held at 0.
- R11: After reset all flags, stored samples and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 4 | Per-channel new-sample strobe |
| sample_data | input | 40 | Channel k sample in bits 10k+9:10k |
| hi_ref | input | 40 | Channel k upper limit in bits 10k+9:10k |
| lo_ref | input | 40 | Channel k lower limit in bits 10k+9:10k |
| flag_rd | input | 1 | Status read strobe; clears the flags after this cycle |
| rd_chan | input | 2 | Channel chosen for sample readback |
| flags_o | output | 8 | Sticky status byte |
| irq_o | output | 1 | Interrupt request |
| data_lo_o | output | 8 | Selected sample, bits 7:0 |
| data_hi_o | output | 8 | Selected sample, bits 9:8 zero-extended |

## Verification
A corrupted flag register is visible in `flags_o` on the very next cycle. It shows up either as a bit that fails to appear after an excursion, or as a bit that survives a read strobe. A wrong limit-qualification mask appears only through `irq_o`, and immediately, because that output has no register of its own. A stale or misaligned sample register appears in the two readback bytes one cycle after the channel's valid strobe. The directed scenarios therefore sample each output in the cycle right after the stimulus edge, including the collision of a read with a fresh excursion.

// File: rtl/qwin_pkg.sv
package qwin_pkg;
  // One channel's excursion pair; packed so {hi,lo} maps onto status bits {2k+1,2k}.
  typedef struct packed {
    logic hi;
    logic lo;
  } win_evt_t;
endpackage

// File: rtl/qwin_chan.sv
module qwin_chan
  import qwin_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] hi_lim,
  input  logic [DW-1:0] lo_lim,
  output win_evt_t      evt,
  output logic [DW-1:0] sample_q
);
  // Excursions are only meaningful on a valid edge.
  always_comb begin
    evt.hi = valid && (data > hi_lim);
    evt.lo = valid && (data < lo_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sample_q <= '0;
    else if (valid) sample_q <= data;
  end
endmodule

// File: rtl/qwin_flags.sv
module qwin_flags #(
  parameter int NCH = 4,
  localparam int FW = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] evt_vec,
  input  logic [FW-1:0] lim_nz,
  input  logic          rd_clr,
  output logic [FW-1:0] flags,
  output logic          irq
);
  logic [FW-1:0] kept;

  // A read wipes the old byte; same-edge events are OR-ed in afterwards.
  assign kept = rd_clr ? '0 : flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | evt_vec;
  end

  assign irq = |(flags & lim_nz);
endmodule

// File: rtl/qwin_readback.sv
module qwin_readback #(
  parameter int NCH  = 4,
  parameter int DW   = 10,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*DW-1:0] samples,
  input  logic [SELW-1:0]   sel,
  output logic [7:0]        lo_byte,
  output logic [7:0]        hi_byte
);
  logic [DW-1:0] picked;
  logic [15:0]   wide;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NCH; k++)
      if (sel == SELW'(k)) picked = samples[k*DW +: DW];
  end

  // Zero-extend to two bytes so unused upper bits read as 0.
  assign wide    = 16'(picked);
  assign lo_byte = wide[7:0];
  assign hi_byte = wide[15:8];
endmodule

// File: rtl/quad_window_irq.sv
module quad_window_irq
  import qwin_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 10,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW   = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    sample_valid,
  input  logic [NCH*DW-1:0] sample_data,
  input  logic [NCH*DW-1:0] hi_ref,
  input  logic [NCH*DW-1:0] lo_ref,
  input  logic              flag_rd,
  input  logic [SELW-1:0]   rd_chan,
  output logic [FW-1:0]     flags_o,
  output logic              irq_o,
  output logic [7:0]        data_lo_o,
  output logic [7:0]        data_hi_o
);
  logic [FW-1:0]     evt_vec;
  logic [FW-1:0]     lim_nz;
  logic [NCH*DW-1:0] samples;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    win_evt_t e;

    qwin_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (sample_valid[k]),
      .data     (sample_data[k*DW +: DW]),
      .hi_lim   (hi_ref[k*DW +: DW]),
      .lo_lim   (lo_ref[k*DW +: DW]),
      .evt      (e),
      .sample_q (samples[k*DW +: DW])
    );

    assign evt_vec[2*k +: 2] = e;
    assign lim_nz[2*k+1]     = |hi_ref[k*DW +: DW];
    assign lim_nz[2*k]       = |lo_ref[k*DW +: DW];
  end

  qwin_flags #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_vec (evt_vec),
    .lim_nz  (lim_nz),
    .rd_clr  (flag_rd),
    .flags   (flags_o),
    .irq     (irq_o)
  );

  qwin_readback #(.NCH(NCH), .DW(DW)) u_rb (
    .samples (samples),
    .sel     (rd_chan),
    .lo_byte (data_lo_o),
    .hi_byte (data_hi_o)
  );
endmodule

// File: rtl/quad_window_irq_chk.sv
module quad_window_irq_chk #(
  parameter int NCH = 4,
  parameter int DW  = 10,
  localparam int FW = 2 * NCH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    sample_valid,
  input logic [NCH*DW-1:0] sample_data,
  input logic [NCH*DW-1:0] hi_ref,
  input logic [NCH*DW-1:0] lo_ref,
  input logic              flag_rd,
  input logic [FW-1:0]     flags_o,
  input logic              irq_o,
  input logic [7:0]        data_hi_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ck
    // R2 and R7: an upper excursion is recorded at its bit regardless of a read
    assert_hi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid[k] && (sample_data[k*DW +: DW] > hi_ref[k*DW +: DW]))
      |=> flags_o[2*k+1]);
    // R3 and R7: a lower excursion is recorded at its bit regardless of a read
    assert_lo_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid[k] && (sample_data[k*DW +: DW] < lo_ref[k*DW +: DW]))
      |=> flags_o[2*k]);
  end

  assert_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid == '0 && !flag_rd) |=> $stable(flags_o));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_rd |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && sample_valid == '0) |=> (flags_o == '0));

  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o == '0) |-> !irq_o);

  assert_hi_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_hi_o >> (DW - 8)) == 8'd0));
endmodule

bind quad_window_irq quad_window_irq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sample_data  (sample_data),
  .hi_ref       (hi_ref),
  .lo_ref       (lo_ref),
  .flag_rd      (flag_rd),
  .flags_o      (flags_o),
  .irq_o        (irq_o),
  .data_hi_o    (data_hi_o)
);

// File: tb/tb_quad_window_irq.sv
`timescale 1ns/1ps
module tb_quad_window_irq;
  localparam int NCH = 4;
  localparam int DW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    sample_valid = '0;
  logic [NCH*DW-1:0] sample_data = '0;
  logic [NCH*DW-1:0] hi_ref = '0;
  logic [NCH*DW-1:0] lo_ref = '0;
  logic              flag_rd = 1'b0;
  logic [1:0]        rd_chan = '0;
  logic [7:0]        flags_o;
  logic              irq_o;
  logic [7:0]        data_lo_o;
  logic [7:0]        data_hi_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_window_irq dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
    .hi_ref(hi_ref), .lo_ref(lo_ref), .flag_rd(flag_rd), .rd_chan(rd_chan),
    .flags_o(flags_o), .irq_o(irq_o), .data_lo_o(data_lo_o), .data_hi_o(data_hi_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_lims(input int ch, input int hi, input int lo);
    hi_ref[ch*DW +: DW] = DW'(hi);
    lo_ref[ch*DW +: DW] = DW'(lo);
  endtask

  task automatic send(input int ch, input int val);
    @(negedge clk);
    sample_data[ch*DW +: DW] = DW'(val);
    sample_valid = '0;
    sample_valid[ch] = 1'b1;
    @(negedge clk);
    sample_valid = '0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "flags after reset", int'(flags_o), 0);
    chk("R11", "irq after reset", int'(irq_o), 0);
    chk("R11", "readback lo after reset", int'(data_lo_o), 0);
    chk("R11", "readback hi after reset", int'(data_hi_o), 0);
  endtask

  task automatic t_limits();
    for (int k = 0; k < NCH; k++) set_lims(k, 600, 200);
    clear_flags();
    send(0, 600);
    chk("R2", "equal to upper limit", int'(flags_o), 8'h00);
    send(0, 601);
    chk("R2", "above upper ch0 bit1 (R1)", int'(flags_o), 8'h02);
    clear_flags();
    send(2, 199);
    chk("R3", "below lower ch2 bit4 (R1)", int'(flags_o), 8'h10);
    clear_flags();
    send(3, 200);
    chk("R3", "equal to lower limit", int'(flags_o), 8'h00);
    send(3, 1023);
    chk("R1", "ch3 high flag bit7", int'(flags_o), 8'h80);
    clear_flags();
    send(1, 0);
    chk("R1", "ch1 low flag bit2", int'(flags_o), 8'h04);
    clear_flags();
  endtask

  task automatic t_no_valid();
    clear_flags();
    @(negedge clk);
    sample_data = '1;
    repeat (3) @(negedge clk);
    chk("R4", "bus change without valid", int'(flags_o), 8'h00);
    sample_data = '0;
  endtask

  task automatic t_sticky();
    clear_flags();
    send(1, 700);
    send(1, 400);
    repeat (3) @(negedge clk);
    chk("R5", "flag held after return to window", int'(flags_o), 8'h08);
  endtask

  task automatic t_clear();
    @(negedge clk);
    flag_rd = 1'b1;
    #1;
    chk("R6", "pre-clear value during read", int'(flags_o), 8'h08);
    @(negedge clk);
    flag_rd = 1'b0;
    chk("R6", "flags after read", int'(flags_o), 8'h00);
  endtask

  task automatic t_collide();
    send(1, 700);
    @(negedge clk);
    flag_rd = 1'b1;
    sample_data[0 +: DW] = DW'(100);
    sample_valid = 4'b0001;
    @(negedge clk);
    flag_rd = 1'b0;
    sample_valid = '0;
    chk("R7", "same-edge event survives clear", int'(flags_o), 8'h01);
    clear_flags();
  endtask

  task automatic t_irq();
    set_lims(0, 0, 0);
    clear_flags();
    send(0, 5);
    chk("R9", "zero-limit flag readable", int'(flags_o), 8'h02);
    chk("R9", "zero-limit flag gated from irq", int'(irq_o), 0);
    @(negedge clk);
    set_lims(0, 3, 0);
    #1;
    chk("R8", "irq once limit non-zero", int'(irq_o), 1);
    clear_flags();
    chk("R8", "irq drops after clear", int'(irq_o), 0);
    send(1, 700);
    chk("R8", "irq from ch1 high", int'(irq_o), 1);
    clear_flags();
    chk("R8", "irq low after second clear", int'(irq_o), 0);
  endtask

  task automatic t_readback();
    send(2, 677);
    send(1, 1023);
    rd_chan = 2'd2;
    #1;
    chk("R10", "ch2 low byte", int'(data_lo_o), 8'hA5);
    chk("R10", "ch2 high byte", int'(data_hi_o), 8'h02);
    rd_chan = 2'd1;
    #1;
    chk("R10", "ch1 low byte", int'(data_lo_o), 8'hFF);
    chk("R10", "ch1 high byte", int'(data_hi_o), 8'h03);
    clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_limits();
    t_no_valid();
    t_sticky();
    t_clear();
    t_collide();
    t_irq();
    t_readback();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule